// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Controller

This block holds the transmit and receive queues of an SPI peripheral and derives all of the peripheral's event signalling from their occupancy. The bus side pushes transmit data and pops receive data, and the serial side does the reverse. Each queue has 32 entries and reports its fill count. The block turns queue conditions and access errors into sticky flags. From these it drives a masked interrupt line, a wake line and one DMA request per direction.

The transmit threshold fires when the transmit queue runs low, below a programmed level. The receive threshold fires when the receive queue runs high, above its level. Overrun and underrun are recorded for both the bus side and the serial side of each queue. A queue clear strobe empties that queue and wipes the flags tied to it. The wake flags are a second sticky bank covering only the four occupancy events. They have their own clear and enable inputs. The serial shifter and the register decoder sit outside this block.

Top module: `spi_fifo_status`

## Requirements
- R1: Each queue is first-in first-out with 32 entries. Its fill count is output as `tx_count`/`rx_count`, registered, and updates on the clock edge after an accepted push or pop.
- R2: A push to a full queue and a pop from an empty queue leave the contents and the count unchanged. The read data of an empty queue is zero.
- R3: `tx_dma_req` is high when `tx_count` < `tx_level`. Flag bit 0 (TX threshold) sets on the edge after that condition is seen.
- R4: `rx_dma_req` is high when `rx_count` > `rx_level`. Flag bit 2 (RX threshold) sets on the edge after that condition is seen.
- R5: The flag bits are 0 TX threshold, 1 TX empty, 2 RX threshold, 3 RX full, 4 TX overrun, 5 TX underrun, 6 RX overrun and 7 RX underrun. Flags are sticky. A 1 in `flag_clr` clears that bit at the next edge, and a 0 leaves it unchanged.
- R6: If a flag's set condition and its `flag_clr` bit occur in the same cycle, the flag ends up set.
- R7: A `bus_push` to a full TX queue sets bit 4. An `spi_pop` from an empty TX queue sets bit 5.
- R8: An `spi_push` to a full RX queue sets bit 6. A `bus_pop` from an empty RX queue sets bit 7.
- R9: `tx_clear` empties the TX queue and clears bits 0, 1, 4 and 5 in both banks. `rx_clear` empties the RX queue and clears bits 2, 3, 6 and 7. Flags of the other queue are untouched.
- R10: A DMA request is low whenever its enable is 0, including a request that was already pending.
- R11: `irq` is the OR over all bits of `flags & irq_en`.
- R12: `wake_flags[3:0]` set on the same conditions as flag bits 3:0 and are cleared only by `wake_clr` or a queue clear. `wake` is the OR of `wake_flags & wake_en`.
- R13: Bit 1 sets when the TX queue is empty, and bit 3 sets when the RX queue holds 32 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_push | input | 1 | Bus writes one TX entry |
| bus_wdata | input | 32 | Data for bus_push |
| bus_pop | input | 1 | Bus reads one RX entry |
| bus_rdata | output | 32 | Head of RX queue, zero when empty |
| spi_push | input | 1 | Serial side writes one RX entry |
| spi_wdata | input | 32 | Data for spi_push |
| spi_pop | input | 1 | Serial side reads one TX entry |
| spi_rdata | output | 32 | Head of TX queue, zero when empty |
| tx_level | input | 6 | TX low-water level |
| rx_level | input | 6 | RX high-water level |
| tx_clear | input | 1 | Empty TX queue and wipe its flags |
| rx_clear | input | 1 | Empty RX queue and wipe its flags |
| flag_clr | input | 8 | Write-1-to-clear strobes for flags |
| irq_en | input | 8 | Interrupt enable per flag |
| wake_clr | input | 4 | Write-1-to-clear strobes for wake flags |
| wake_en | input | 4 | Wake enable per wake flag |
| tx_dma_en | input | 1 | TX DMA request enable |
| rx_dma_en | input | 1 | RX DMA request enable |
| flags | output | 8 | Sticky event flags |
| wake_flags | output | 4 | Sticky wake flags |
| tx_count | output | 6 | TX fill count |
| rx_count | output | 6 | RX fill count |
| irq | output | 1 | Masked interrupt |
| wake | output | 1 | Masked wake |
| tx_dma_req | output | 1 | TX DMA request |
| rx_dma_req | output | 1 | RX DMA request |

## Verification
The queues are driven with short ordered bursts, with fills to exactly 32 followed by one extra push, and with pops from an empty queue. These patterns separate correct ordering from the overrun and underrun edges. The thresholds are tested at counts one below, at and one above the level, which tells the strict less-than and greater-than comparisons apart from off-by-one variants. The clear-strobe cases combine a set event with a clear of the same bit, or a clear of the other queue. This shows that set wins over clear and that each queue clear touches only its own flags. The mask tests enable and disable single bits to show which flags reach `irq` and which reach `wake`.

// File: rtl/spi_fifo_status_pkg.sv
// Shared constants for the SPI queue status block: flag bit indices and sizes.
package spi_fifo_status_pkg;
    localparam int NFLAG      = 8;
    localparam int NWAKE      = 4;
    localparam int F_TX_THR   = 0;
    localparam int F_TX_EMPTY = 1;
    localparam int F_RX_THR   = 2;
    localparam int F_RX_FULL  = 3;
    localparam int F_TX_OVR   = 4;
    localparam int F_TX_UND   = 5;
    localparam int F_RX_OVR   = 6;
    localparam int F_RX_UND   = 7;
endpackage

// File: rtl/sfs_queue.sv
// Synchronous FIFO with show-ahead read port and fill count.
// Assumes: a push when full and a pop when empty are dropped; clr empties the
// queue and takes priority over push and pop in the same cycle.
module sfs_queue #(
    parameter int DW    = 32,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign rdata   = empty ? '0 : mem[rp];

    // Storage write; no reset needed for data.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    // Pointer and count update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    a_r2_full_push_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> (count == CW'(DEPTH)));
    a_r2_empty_pop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !clr) |=> (count == '0));
    a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));
endmodule

// File: rtl/sfs_flag_bank.sv
// Bank of sticky write-1-to-clear flags.
// Assumes: wipe beats set, set beats w1c, so an event coinciding with a
// software clear is kept.
module sfs_flag_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] w1c,
    input  logic [N-1:0] wipe,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // Per-bit sticky register with wipe > set > clear priority.
        always_ff @(posedge clk) begin
            if (!rst_n || wipe[i]) q[i] <= 1'b0;
            else if (set[i])       q[i] <= 1'b1;
            else if (w1c[i])       q[i] <= 1'b0;
        end

        a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (set[i] && !wipe[i]) |=> q[i]);
        a_r5_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (w1c[i] && !set[i]) |=> !q[i]);
        a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (q[i] && !w1c[i] && !wipe[i]) |=> q[i]);
    end
endmodule

// File: rtl/spi_fifo_status.sv
// SPI peripheral queue pair with sticky status, interrupt, wake and DMA requests.
// Assumes: one push and one pop strobe per side per cycle; thresholds compare
// against registered counts, so threshold flags lag a count change by one edge.
module spi_fifo_status
    import spi_fifo_status_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 32,
    parameter int LW    = 6,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_push,
    input  logic [DW-1:0]    bus_wdata,
    input  logic             bus_pop,
    output logic [DW-1:0]    bus_rdata,
    input  logic             spi_push,
    input  logic [DW-1:0]    spi_wdata,
    input  logic             spi_pop,
    output logic [DW-1:0]    spi_rdata,
    input  logic [LW-1:0]    tx_level,
    input  logic [LW-1:0]    rx_level,
    input  logic             tx_clear,
    input  logic             rx_clear,
    input  logic [NFLAG-1:0] flag_clr,
    input  logic [NFLAG-1:0] irq_en,
    input  logic [NWAKE-1:0] wake_clr,
    input  logic [NWAKE-1:0] wake_en,
    input  logic             tx_dma_en,
    input  logic             rx_dma_en,
    output logic [NFLAG-1:0] flags,
    output logic [NWAKE-1:0] wake_flags,
    output logic [CW-1:0]    tx_count,
    output logic [CW-1:0]    rx_count,
    output logic             irq,
    output logic             wake,
    output logic             tx_dma_req,
    output logic             rx_dma_req
);
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic tx_low, rx_high;
    logic [NFLAG-1:0] set_v, wipe_v;

    sfs_queue #(.DW(DW), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(tx_clear),
        .push(bus_push), .wdata(bus_wdata), .pop(spi_pop), .rdata(spi_rdata),
        .count(tx_count), .full(tx_full), .empty(tx_empty));

    sfs_queue #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(rx_clear),
        .push(spi_push), .wdata(spi_wdata), .pop(bus_pop), .rdata(bus_rdata),
        .count(rx_count), .full(rx_full), .empty(rx_empty));

    // Thresholds: TX asks for more data when low, RX asks to be drained when high.
    always_comb begin
        tx_low  = (32'(tx_count) < 32'(tx_level));
        rx_high = (32'(rx_count) > 32'(rx_level));
    end

    // Flag set conditions and per-queue wipe masks.
    always_comb begin
        set_v             = '0;
        set_v[F_TX_THR]   = tx_low;
        set_v[F_TX_EMPTY] = tx_empty;
        set_v[F_RX_THR]   = rx_high;
        set_v[F_RX_FULL]  = rx_full;
        set_v[F_TX_OVR]   = bus_push && tx_full;
        set_v[F_TX_UND]   = spi_pop && tx_empty;
        set_v[F_RX_OVR]   = spi_push && rx_full;
        set_v[F_RX_UND]   = bus_pop && rx_empty;
        wipe_v            = '0;
        wipe_v[F_TX_THR]  = tx_clear;
        wipe_v[F_TX_EMPTY]= tx_clear;
        wipe_v[F_TX_OVR]  = tx_clear;
        wipe_v[F_TX_UND]  = tx_clear;
        wipe_v[F_RX_THR]  = rx_clear;
        wipe_v[F_RX_FULL] = rx_clear;
        wipe_v[F_RX_OVR]  = rx_clear;
        wipe_v[F_RX_UND]  = rx_clear;
    end

    sfs_flag_bank #(.N(NFLAG)) u_irq_flags (
        .clk(clk), .rst_n(rst_n), .set(set_v), .w1c(flag_clr),
        .wipe(wipe_v), .q(flags));

    sfs_flag_bank #(.N(NWAKE)) u_wake_flags (
        .clk(clk), .rst_n(rst_n), .set(set_v[NWAKE-1:0]), .w1c(wake_clr),
        .wipe(wipe_v[NWAKE-1:0]), .q(wake_flags));

    // Masked event outputs and gated DMA requests.
    always_comb begin
        irq        = |(flags & irq_en);
        wake       = |(wake_flags & wake_en);
        tx_dma_req = tx_dma_en && tx_low;
        rx_dma_req = rx_dma_en && rx_high;
    end

    a_r3_tx_req_low: assert property (@(posedge clk) disable iff (!rst_n)
        tx_dma_req |-> (32'(tx_count) < 32'(tx_level)));
    a_r4_rx_req_high: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dma_req |-> (32'(rx_count) > 32'(rx_level)));
    a_r10_dma_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_dma_en || rx_dma_en) |-> !(tx_dma_req || rx_dma_req));
    a_r7_tx_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_push && tx_full && !tx_clear) |=> flags[F_TX_OVR]);
    a_r8_rx_underrun: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_pop && rx_empty && !rx_clear) |=> flags[F_RX_UND]);
    a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags != '0));
endmodule

// File: tb/spi_fifo_status_test.sv
`timescale 1ns/1ps
module spi_fifo_status_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_push = 0, bus_pop = 0, spi_push = 0, spi_pop = 0;
    logic [31:0] bus_wdata = '0, spi_wdata = '0;
    logic [31:0] bus_rdata, spi_rdata;
    logic [5:0]  tx_level = 6'd0, rx_level = 6'd63;
    logic        tx_clear = 0, rx_clear = 0;
    logic [7:0]  flag_clr = '0, irq_en = '0;
    logic [3:0]  wake_clr = '0, wake_en = '0;
    logic        tx_dma_en = 0, rx_dma_en = 0;
    logic [7:0]  flags;
    logic [3:0]  wake_flags;
    logic [5:0]  tx_count, rx_count;
    logic        irq, wake, tx_dma_req, rx_dma_req;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    spi_fifo_status uut (
        .clk(clk), .rst_n(rst_n),
        .bus_push(bus_push), .bus_wdata(bus_wdata), .bus_pop(bus_pop), .bus_rdata(bus_rdata),
        .spi_push(spi_push), .spi_wdata(spi_wdata), .spi_pop(spi_pop), .spi_rdata(spi_rdata),
        .tx_level(tx_level), .rx_level(rx_level), .tx_clear(tx_clear), .rx_clear(rx_clear),
        .flag_clr(flag_clr), .irq_en(irq_en), .wake_clr(wake_clr), .wake_en(wake_en),
        .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en), .flags(flags), .wake_flags(wake_flags),
        .tx_count(tx_count), .rx_count(rx_count), .irq(irq), .wake(wake),
        .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req));

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock edge; strobes drop afterwards; caller samples at the falling edge.
    task automatic tick();
        @(negedge clk);
        bus_push = 0; bus_pop = 0; spi_push = 0; spi_pop = 0;
        tx_clear = 0; rx_clear = 0; flag_clr = '0; wake_clr = '0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 reset tx_count", tx_count, 0);
        chk("R1 reset rx_count", rx_count, 0);
        chk("R5 reset flags", flags, 0);
        chk("R12 reset wake_flags", wake_flags, 0);
        chk("R11 reset irq", irq, 0);
        rst_n = 1'b1;
        tick(); tick();
    endtask

    task automatic t_order();
        for (int i = 0; i < 5; i++) begin
            bus_push = 1; bus_wdata = 32'hA0 + i; tick();
        end
        chk("R1 tx count after 5", tx_count, 5);
        for (int i = 0; i < 5; i++) begin
            chk("R1 tx order", spi_rdata, 32'hA0 + i);
            spi_pop = 1; tick();
        end
        chk("R1 tx count drained", tx_count, 0);
    endtask

    task automatic t_tx_thresh();
        tx_level = 6'd3; tx_dma_en = 1; tick();
        chk("R3 req at count 0 level 3", tx_dma_req, 1);
        for (int i = 0; i < 3; i++) begin
            bus_push = 1; bus_wdata = i; tick();
        end
        chk("R3 req at count=level", tx_dma_req, 0);
        flag_clr = 8'h01; tick(); tick();
        chk("R3 thresh flag stays clear at level", flags[0], 0);
        spi_pop = 1; tick(); tick();
        chk("R3 thresh flag below level", flags[0], 1);
        chk("R3 req below level", tx_dma_req, 1);
        tx_dma_en = 0; tick();
        chk("R10 tx req dropped", tx_dma_req, 0);
        spi_pop = 1; tick(); spi_pop = 1; tick();
        tx_level = 6'd0;
    endtask

    task automatic t_rx_thresh();
        rx_level = 6'd2; rx_dma_en = 1;
        for (int i = 0; i < 2; i++) begin
            spi_push = 1; spi_wdata = 32'h50 + i; tick();
        end
        chk("R4 req at count=level", rx_dma_req, 0);
        spi_push = 1; spi_wdata = 32'h52; tick();
        chk("R4 req above level", rx_dma_req, 1);
        tick();
        chk("R4 thresh flag above level", flags[2], 1);
        rx_dma_en = 0; tick();
        chk("R10 rx req dropped", rx_dma_req, 0);
        for (int i = 0; i < 3; i++) begin
            chk("R1 rx order", bus_rdata, 32'h50 + i);
            bus_pop = 1; tick();
        end
        rx_level = 6'd63;
    endtask

    task automatic t_rx_full();
        for (int i = 0; i < 32; i++) begin
            spi_push = 1; spi_wdata = 32'h100 + i; tick();
        end
        chk("R1 rx count 32", rx_count, 32);
        tick();
        chk("R13 rx full flag", flags[3], 1);
        spi_push = 1; spi_wdata = 32'hDEAD; tick();
        chk("R8 rx overrun flag", flags[6], 1);
        chk("R2 rx count held on overrun", rx_count, 32);
        for (int i = 0; i < 32; i++) begin
            if (bus_rdata !== 32'h100 + i) chk("R2 rx contents", bus_rdata, 32'h100 + i);
            bus_pop = 1; tick();
        end
        n_run++;
        chk("R2 empty read data zero", bus_rdata, 0);
        chk("R8 no underrun yet", flags[7], 0);
        bus_pop = 1; tick();
        chk("R8 rx underrun flag", flags[7], 1);
        chk("R2 rx count held on underrun", rx_count, 0);
    endtask

    task automatic t_w1c();
        flag_clr = 8'h40; tick();
        chk("R5 w1c clears bit 6", flags[6], 0);
        chk("R5 zero leaves bit 7", flags[7], 1);
        tick();
        chk("R5 idle keeps bit 7", flags[7], 1);
        bus_pop = 1; flag_clr = 8'h80; tick();
        chk("R6 set beats clear", flags[7], 1);
        flag_clr = 8'h80; tick();
        chk("R5 w1c clears bit 7", flags[7], 0);
    endtask

    task automatic t_tx_full_clear();
        for (int i = 0; i < 32; i++) begin
            bus_push = 1; bus_wdata = i; tick();
        end
        bus_push = 1; tick();
        chk("R7 tx overrun flag", flags[4], 1);
        chk("R2 tx count held", tx_count, 32);
        bus_pop = 1; tick();
        tx_clear = 1; tick();
        chk("R9 tx clear empties", tx_count, 0);
        chk("R9 tx clear wipes overrun", flags[4], 0);
        chk("R9 tx clear keeps rx flag", flags[7], 1);
        chk("R2 tx empty read zero", spi_rdata, 0);
        spi_pop = 1; tick();
        chk("R7 tx underrun flag", flags[5], 1);
        spi_push = 1; tick(); spi_push = 1; tick();
        rx_clear = 1; tick();
        chk("R9 rx clear empties", rx_count, 0);
        chk("R9 rx clear wipes underrun", flags[7], 0);
        chk("R9 rx clear keeps tx flag", flags[5], 1);
    endtask

    task automatic t_irq_wake();
        irq_en = '0; wake_en = 4'hF; tx_level = 6'd0;
        bus_push = 1; tick();
        flag_clr = 8'hFF; wake_clr = 4'hF; tick(); tick();
        chk("R5 all flags clear", flags, 0);
        chk("R12 wake low when clear", wake, 0);
        spi_pop = 1; tick(); tick();
        chk("R13 tx empty flag", flags[1], 1);
        bus_push = 1; tick();
        flag_clr = 8'hFF; tick();
        chk("R12 wake flag survives irq clear", wake_flags[1], 1);
        chk("R12 wake enabled", wake, 1);
        wake_en = 4'b1101; tick();
        chk("R12 wake masked", wake, 0);
        irq_en = 8'hFF; tick();
        chk("R11 irq low no flags", irq, 0);
        bus_pop = 1; tick();
        chk("R11 irq from rx underrun", irq, 1);
        chk("R12 wake ignores bit 7", wake, 0);
        irq_en = 8'h7F; tick();
        chk("R11 irq masked", irq, 0);
        wake_clr = 4'h2; tick();
        chk("R12 wake flag w1c", wake_flags[1], 0);
    endtask

    initial begin
        t_reset();
        t_order();
        t_tx_thresh();
        t_rx_thresh();
        t_rx_full();
        t_w1c();
        t_tx_full_clear();
        t_irq_wake();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule